// File: doc/BRIEF.md
# RTC Dual Alarm Interrupt Controller

This block holds two time-of-day alarms for a real-time clock and turns matches against the running time into interrupt requests. The timekeeping counter sits outside the block. It presents its seconds, minutes, hours and day values on input ports, together with a one-cycle update strobe. On each update strobe the block compares every alarm field with the matching time field. A field whose mask bit is set counts as matching, so each alarm can repeat every second, every minute, every hour, every day or once per week.

A match latches a request flag for that alarm. Each flag drives one of two active-low interrupt pins, gated by a per-alarm enable. A routing bit either gives each alarm its own pin or merges both alarms onto the first pin. Software reaches the alarm, control and status registers through a byte-wide register port with an address, a read strobe and a write strobe. Any access to an alarm's registers clears that alarm's flag. A write-protect bit in the control register locks every register. The only write it accepts is one that removes the lock.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, the control register reads 0x80 (oscillator-stop bit set, all else clear), the status register reads 0x00, `oscStop` is 1 and both interrupt pins are high.
- R2: Read addresses are: alarm 0 seconds, minutes, hours and day at 0x07, 0x08, 0x09 and 0x0A; alarm 1 at 0x0B to 0x0E in the same field order; control at 0x0F; status at 0x10. The write address of each writable register is its read address plus 0x80. `rdData` shows the register at `addr` combinationally and reads 0x00 for any other address, write addresses included. Control bits are: 7 oscillator stop (driven on `oscStop`), 6 write protect, 2 routing, 1 enable for alarm 1, 0 enable for alarm 0. Status bit 1 is the alarm 1 flag and bit 0 is the alarm 0 flag.
- R3: In each alarm field, bit 7 is a mask and bits 6:0 are compared with the 7-bit time input for that field. When `tickStb` is high and all four fields of an alarm match (masked or equal), that alarm's flag reads 1 from the next cycle on. The mask combinations tested are: all four masked; only seconds compared; seconds and minutes compared; seconds, minutes and hours compared; all four compared.
- R4: A flag is never set in a cycle without `tickStb`, even if the time inputs match.
- R5: With the routing bit at 1, `irq0N` is low exactly when flag 0 and enable 0 are both 1, and `irq1N` is low exactly when flag 1 and enable 1 are both 1.
- R6: With the routing bit at 0, `irq0N` is low when (flag 0 and enable 0) or (flag 1 and enable 1), and `irq1N` stays high.
- R7: A read strobe at one of an alarm's read addresses, or a write strobe at one of its write addresses, clears that alarm's flag at the next edge. This holds even while writes are locked. Accesses to other addresses, and to the other alarm, leave the flag as it is.
- R8: If an alarm matches on an update strobe in the same cycle that an access clears its flag, the flag ends up set.
- R9: While write protect is 1, writes to alarm registers are ignored. A control write with bit 6 at 0 clears write protect only and leaves the other control bits unchanged. A control write with bit 6 at 1 changes nothing.
- R10: Writes to 0x90 (status plus 0x80) change nothing. Control bits 5:3 ignore writes and always read 0.
- R11: The enable bits only gate the pins. A flag is set on a match whether or not its enable is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| rdEn | input | 1 | Read strobe, one cycle per access |
| wrEn | input | 1 | Write strobe, one cycle per access |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| tickStb | input | 1 | One-cycle strobe on each clock update |
| timeSec | input | 7 | Current seconds value |
| timeMin | input | 7 | Current minutes value |
| timeHour | input | 7 | Current hours value |
| timeDay | input | 7 | Current day value |
| irq0N | output | 1 | Active-low interrupt pin 0 |
| irq1N | output | 1 | Active-low interrupt pin 1 |
| oscStop | output | 1 | Oscillator-stop control bit |

## Verification
The bench sweeps the mask combinations and includes near-miss times that differ in exactly one field. A design that compared a masked field, or skipped a field, would raise a flag the reference model does not expect. It fires an update strobe and an alarm read in the same cycle, where a design giving priority to the clear would lose the interrupt. It also reads the other alarm while a flag is pending, which exposes a decoder that clears both flags. Under write protect it tries an alarm write, a control write that keeps the lock, and a control write that releases it. A design that let the releasing write also load the other control bits would show a wrong control value. The pins are compared against the model on every clock in both routing modes and with the enables off. This catches a design that lets `irq1N` fire while the alarms are merged, or that gates the flag with its enable.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int DATA_W    = 8;
  localparam int TIME_W    = DATA_W - 1;
  localparam int MASK_BIT  = DATA_W - 1;
  localparam int NUM_ALM   = 2;
  localparam int NUM_FIELD = 4;
  localparam int ALM_IDX_W = $clog2(NUM_ALM);
  localparam int FIELD_W   = $clog2(NUM_FIELD);

  // control register bit positions
  localparam int CTL_OSC   = 7;
  localparam int CTL_WP    = 6;
  localparam int CTL_ROUTE = 2;
  localparam int CTL_EN1   = 1;
  localparam int CTL_EN0   = 0;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_ALM,
    RD_CTL,
    RD_STS
  } rdSrc_e;

  // strobes from the address decoder to the register datapath
  typedef struct packed {
    logic                 almWr;
    logic [ALM_IDX_W-1:0] almIdx;
    logic [FIELD_W-1:0]   fieldIdx;
    logic                 ctlWr;
    logic                 ctlLocked;
    logic [NUM_ALM-1:0]   flagClr;
    rdSrc_e               rdSrc;
  } ctlStb_t;

endpackage

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ALM_BASE  = 7,
  parameter int CTL_ADDR  = 15,
  parameter int STS_ADDR  = 16,
  parameter int WR_OFFSET = 128
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              wpQ,
  output ctlStb_t           stb
);

  localparam int ALM_SPAN = NUM_ALM * NUM_FIELD;
  localparam logic [ADDR_W-1:0] RD_LO  = ADDR_W'(ALM_BASE);
  localparam logic [ADDR_W-1:0] RD_HI  = ADDR_W'(ALM_BASE + ALM_SPAN - 1);
  localparam logic [ADDR_W-1:0] WR_LO  = ADDR_W'(ALM_BASE + WR_OFFSET);
  localparam logic [ADDR_W-1:0] WR_HI  = ADDR_W'(ALM_BASE + WR_OFFSET + ALM_SPAN - 1);
  localparam logic [ADDR_W-1:0] CTL_RD = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] CTL_WR = ADDR_W'(CTL_ADDR + WR_OFFSET);
  localparam logic [ADDR_W-1:0] STS_RD = ADDR_W'(STS_ADDR);

  logic                 inRdAlm;
  logic                 inWrAlm;
  logic [ADDR_W-1:0]    rdOff;
  logic [ADDR_W-1:0]    wrOff;
  logic [ADDR_W-1:0]    selOff;
  logic [ALM_IDX_W-1:0] rdIdx;
  logic [ALM_IDX_W-1:0] wrIdx;

  assign inRdAlm = (addr >= RD_LO) && (addr <= RD_HI);
  assign inWrAlm = (addr >= WR_LO) && (addr <= WR_HI);
  assign rdOff   = addr - RD_LO;
  assign wrOff   = addr - WR_LO;
  assign selOff  = inWrAlm ? wrOff : rdOff;
  assign rdIdx   = ALM_IDX_W'(rdOff >> FIELD_W);
  assign wrIdx   = ALM_IDX_W'(wrOff >> FIELD_W);

  // one clear strobe per alarm, from a read or a write hitting its block
  logic [NUM_ALM-1:0] clrVec;
  for (genvar i = 0; i < NUM_ALM; i++) begin : g_clr
    assign clrVec[i] = (rdEn && inRdAlm && (rdIdx == ALM_IDX_W'(i))) ||
                       (wrEn && inWrAlm && (wrIdx == ALM_IDX_W'(i)));
  end

  always_comb begin
    stb           = '0;
    stb.almIdx    = ALM_IDX_W'(selOff >> FIELD_W);
    stb.fieldIdx  = FIELD_W'(selOff);
    stb.almWr     = wrEn && inWrAlm && !wpQ;
    stb.ctlWr     = wrEn && (addr == CTL_WR);
    stb.ctlLocked = wpQ;
    stb.flagClr   = clrVec;
    if (inRdAlm)               stb.rdSrc = RD_ALM;
    else if (addr == CTL_RD)   stb.rdSrc = RD_CTL;
    else if (addr == STS_RD)   stb.rdSrc = RD_STS;
    else                       stb.rdSrc = RD_NONE;
  end

endmodule

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  ctlStb_t                             stb,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic                                tickStb,
  input  logic [NUM_FIELD-1:0][TIME_W-1:0]    curTime,
  output logic [DATA_W-1:0]                   rdData,
  output logic                                wpQ,
  output logic                                oscQ,
  output logic                                routeQ,
  output logic [NUM_ALM-1:0]                  enQ,
  output logic [NUM_ALM-1:0]                  flagQ
);

  logic [NUM_ALM-1:0][NUM_FIELD-1:0][DATA_W-1:0] almQ;
  logic [NUM_ALM-1:0][NUM_FIELD-1:0]             fieldHit;
  logic [NUM_ALM-1:0]                            almHit;
  logic                                          unusedCtlBits;

  assign unusedCtlBits = ^wrData[CTL_WP-1:CTL_ROUTE+1];

  // per-field compare, masked fields always hit
  for (genvar a = 0; a < NUM_ALM; a++) begin : g_alm
    for (genvar f = 0; f < NUM_FIELD; f++) begin : g_fld
      assign fieldHit[a][f] = almQ[a][f][MASK_BIT] ||
                              (almQ[a][f][TIME_W-1:0] == curTime[f]);
    end
    assign almHit[a] = tickStb && (&fieldHit[a]);
  end

  // alarm registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      almQ <= '0;
    end else if (stb.almWr) begin
      for (int a = 0; a < NUM_ALM; a++) begin
        for (int f = 0; f < NUM_FIELD; f++) begin
          if ((stb.almIdx == ALM_IDX_W'(a)) && (stb.fieldIdx == FIELD_W'(f))) begin
            almQ[a][f] <= wrData;
          end
        end
      end
    end
  end

  // request flags: a match wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
    end else begin
      for (int a = 0; a < NUM_ALM; a++) begin
        if (almHit[a])            flagQ[a] <= 1'b1;
        else if (stb.flagClr[a])  flagQ[a] <= 1'b0;
      end
    end
  end

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscQ   <= 1'b1;
      wpQ    <= 1'b0;
      routeQ <= 1'b0;
      enQ    <= '0;
    end else if (stb.ctlWr) begin
      if (stb.ctlLocked) begin
        if (!wrData[CTL_WP]) wpQ <= 1'b0;
      end else begin
        oscQ   <= wrData[CTL_OSC];
        wpQ    <= wrData[CTL_WP];
        routeQ <= wrData[CTL_ROUTE];
        enQ    <= {wrData[CTL_EN1], wrData[CTL_EN0]};
      end
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    unique case (stb.rdSrc)
      RD_ALM: rdData = almQ[stb.almIdx][stb.fieldIdx];
      RD_CTL: begin
        rdData[CTL_OSC]   = oscQ;
        rdData[CTL_WP]    = wpQ;
        rdData[CTL_ROUTE] = routeQ;
        rdData[CTL_EN1]   = enQ[1];
        rdData[CTL_EN0]   = enQ[0];
      end
      RD_STS: rdData[NUM_ALM-1:0] = flagQ;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/rtc_alarm_route.sv
module rtc_alarm_route
  import rtc_alarm_pkg::*;
(
  input  logic [NUM_ALM-1:0] flagQ,
  input  logic [NUM_ALM-1:0] enQ,
  input  logic               routeQ,
  output logic               irq0N,
  output logic               irq1N
);

  logic [NUM_ALM-1:0] req;

  assign req   = flagQ & enQ;
  assign irq0N = !(req[0] || (!routeQ && req[1]));
  assign irq1N = !(routeQ && req[1]);

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ALM_BASE  = 7,
  parameter int CTL_ADDR  = 15,
  parameter int STS_ADDR  = 16,
  parameter int WR_OFFSET = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              tickStb,
  input  logic [TIME_W-1:0] timeSec,
  input  logic [TIME_W-1:0] timeMin,
  input  logic [TIME_W-1:0] timeHour,
  input  logic [TIME_W-1:0] timeDay,
  output logic              irq0N,
  output logic              irq1N,
  output logic              oscStop
);

  ctlStb_t                            stb;
  logic                               wpQ;
  logic                               routeQ;
  logic [NUM_ALM-1:0]                 enQ;
  logic [NUM_ALM-1:0]                 flagQ;
  logic [NUM_FIELD-1:0][TIME_W-1:0]   curTime;

  assign curTime = {timeDay, timeHour, timeMin, timeSec};

  rtc_alarm_ctrl #(
    .ADDR_W   (ADDR_W),
    .ALM_BASE (ALM_BASE),
    .CTL_ADDR (CTL_ADDR),
    .STS_ADDR (STS_ADDR),
    .WR_OFFSET(WR_OFFSET)
  ) u_ctrl (
    .addr (addr),
    .rdEn (rdEn),
    .wrEn (wrEn),
    .wpQ  (wpQ),
    .stb  (stb)
  );

  rtc_alarm_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .tickStb(tickStb),
    .curTime(curTime),
    .rdData (rdData),
    .wpQ    (wpQ),
    .oscQ   (oscStop),
    .routeQ (routeQ),
    .enQ    (enQ),
    .flagQ  (flagQ)
  );

  rtc_alarm_route u_route (
    .flagQ (flagQ),
    .enQ   (enQ),
    .routeQ(routeQ),
    .irq0N (irq0N),
    .irq1N (irq1N)
  );

endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
  parameter int ADDR_W = 8,
  parameter int ALM_LO = 7,
  parameter int CTL_WR = 143
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              rdEn,
  input logic              wrEn,
  input logic              tickStb,
  input logic              irq0N,
  input logic              irq1N,
  input logic [1:0]        flagQ,
  input logic [1:0]        enQ,
  input logic              routeQ,
  input logic              wpQ
);

  p_flag0_needs_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ[0]) |-> $past(tickStb));

  p_flag1_needs_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ[1]) |-> $past(tickStb));

  // R7: an alarm 0 read with no update clears flag 0
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !tickStb && (int'(addr) >= ALM_LO) && (int'(addr) < ALM_LO + 4))
    |=> !flagQ[0]);

  p_pin1_idle_merged_r6: assert property (@(posedge clk) disable iff (!rstN)
    !routeQ |-> irq1N);

  p_pin0_has_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    !irq0N |-> ((flagQ & enQ) != 2'b00));

  p_pin1_gated_r11: assert property (@(posedge clk) disable iff (!rstN)
    !enQ[1] |-> irq1N);

  p_unlock_by_ctl_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wpQ) |-> $past(wrEn && (int'(addr) == CTL_WR)));

  p_lock_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wpQ && wrEn && (int'(addr) != CTL_WR)) |=> wpQ);

endmodule

bind rtc_alarm_irq rtc_alarm_chk #(
  .ADDR_W(ADDR_W),
  .ALM_LO(ALM_BASE),
  .CTL_WR(CTL_ADDR + WR_OFFSET)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .addr   (addr),
  .rdEn   (rdEn),
  .wrEn   (wrEn),
  .tickStb(tickStb),
  .irq0N  (irq0N),
  .irq1N  (irq1N),
  .flagQ  (flagQ),
  .enQ    (enQ),
  .routeQ (routeQ),
  .wpQ    (wpQ)
);

// File: tb/tb_rtc_alarm_irq.sv
`timescale 1ns/1ps
module tb_rtc_alarm_irq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic       tickStb = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [6:0] tS = 7'd0, tM = 7'd0, tH = 7'd0, tD = 7'd0;
  logic [7:0] rdData;
  logic       irq0N, irq1N, oscStop;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rtc_alarm_irq dut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .tickStb(tickStb),
    .timeSec(tS), .timeMin(tM), .timeHour(tH), .timeDay(tD),
    .irq0N(irq0N), .irq1N(irq1N), .oscStop(oscStop)
  );

  // ---------------- reference model ----------------
  logic [7:0] mAlm [2][4];
  logic       mOsc, mWp, mRoute;
  logic [1:0] mEn, mFlag;

  function automatic logic fieldOk(logic [7:0] r, logic [6:0] t);
    return r[7] || (r[6:0] == t);
  endfunction

  function automatic logic almHit(int a);
    return fieldOk(mAlm[a][0], tS) && fieldOk(mAlm[a][1], tM) &&
           fieldOk(mAlm[a][2], tH) && fieldOk(mAlm[a][3], tD);
  endfunction

  always @(posedge clk or negedge rstN) begin : mdl
    logic [1:0] hitNow, clrNow;
    int ai;
    if (!rstN) begin
      for (int a = 0; a < 2; a++) for (int f = 0; f < 4; f++) mAlm[a][f] = 8'h00;
      mOsc = 1'b1; mWp = 1'b0; mRoute = 1'b0; mEn = 2'b00; mFlag = 2'b00;
    end else begin
      ai = int'(addr);
      for (int a = 0; a < 2; a++) begin
        hitNow[a] = tickStb && almHit(a);
        clrNow[a] = (rdEn && ai >= 7 + 4*a && ai <= 10 + 4*a) ||
                    (wrEn && ai >= 135 + 4*a && ai <= 138 + 4*a);
      end
      if (wrEn && !mWp && ai >= 135 && ai <= 142)
        mAlm[(ai-135)/4][(ai-135)%4] = wrData;
      if (wrEn && ai == 143) begin
        if (mWp) begin
          if (!wrData[6]) mWp = 1'b0;
        end else begin
          mOsc = wrData[7]; mWp = wrData[6]; mRoute = wrData[2]; mEn = wrData[1:0];
        end
      end
      for (int a = 0; a < 2; a++) begin
        if (hitNow[a])      mFlag[a] = 1'b1;
        else if (clrNow[a]) mFlag[a] = 1'b0;
      end
    end
  end

  function automatic logic [7:0] modelRd(logic [7:0] a);
    int ai = int'(a);
    if (ai >= 7 && ai <= 14) return mAlm[(ai-7)/4][(ai-7)%4];
    if (ai == 15) return {mOsc, mWp, 3'b000, mRoute, mEn};
    if (ai == 16) return {6'b0, mFlag};
    return 8'h00;
  endfunction

  // ---------------- checking ----------------
  task automatic checkEq(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // pins compared with the model on every clock
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checkEq("R5/R6 irq0N", {7'b0, irq0N},
              {7'b0, !((mFlag[0] & mEn[0]) | (!mRoute & mFlag[1] & mEn[1]))});
      checkEq("R5/R6 irq1N", {7'b0, irq1N}, {7'b0, !(mRoute & mFlag[1] & mEn[1])});
      checkEq("R2 oscStop", {7'b0, oscStop}, {7'b0, mOsc});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    @(negedge clk); addr = a; rdEn = 1'b1;
    #1 checkEq(tag, rdData, modelRd(a));
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic peek(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk); addr = a;
    #1 checkEq(tag, rdData, exp);
    checkEq(tag, rdData, modelRd(a));
  endtask

  task automatic tick(logic [6:0] s, logic [6:0] m, logic [6:0] h, logic [6:0] d);
    @(negedge clk); tS = s; tM = m; tH = h; tD = d; tickStb = 1'b1;
    @(negedge clk); tickStb = 1'b0;
  endtask

  task automatic pin(string tag, logic a0, logic a1);
    checkEq(tag, {7'b0, irq0N}, {7'b0, a0});
    checkEq(tag, {7'b0, irq1N}, {7'b0, a1});
  endtask

  initial begin
    #400000;
    checkEq("watchdog", 8'h01, 8'h00);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    peek(8'h0F, 8'h80, "R1 control");
    peek(8'h10, 8'h00, "R1 status");
    pin("R1 pins", 1'b1, 1'b1);
    checkEq("R1 oscStop", {7'b0, oscStop}, 8'h01);

    // R2 register map
    wr(8'h8F, 8'h07);
    peek(8'h0F, 8'h07, "R2 control");
    wr(8'h87, 8'h30); wr(8'h88, 8'h15); wr(8'h89, 8'h09); wr(8'h8A, 8'h03);
    wr(8'h8B, 8'h45); wr(8'h8C, 8'h80); wr(8'h8D, 8'h80); wr(8'h8E, 8'h80);
    peek(8'h07, 8'h30, "R2 alarm0 sec");
    peek(8'h0A, 8'h03, "R2 alarm0 day");
    peek(8'h0B, 8'h45, "R2 alarm1 sec");
    peek(8'h0E, 8'h80, "R2 alarm1 day");
    peek(8'h05, 8'h00, "R2 unmapped");
    peek(8'h8F, 8'h00, "R2 write address reads 0");

    // R10 read-only and reserved bits
    wr(8'h90, 8'hFF);
    peek(8'h10, 8'h00, "R10 status write");
    wr(8'h8F, 8'h3F);
    peek(8'h0F, 8'h07, "R10 reserved bits");

    // R3 all fields compared
    tick(7'h30, 7'h15, 7'h09, 7'h03);
    peek(8'h10, 8'h01, "R3 full match");
    pin("R5 separate pins", 1'b0, 1'b1);

    // R7 read clears
    rd(8'h08, "R7 read alarm0");
    peek(8'h10, 8'h00, "R7 read clear");

    // R3 day mismatch
    tick(7'h30, 7'h15, 7'h09, 7'h04);
    peek(8'h10, 8'h00, "R3 day differs");

    // R4 matching time without strobe
    @(negedge clk); tS = 7'h45; tM = 7'h00; tH = 7'h00; tD = 7'h00;
    repeat (3) @(negedge clk);
    peek(8'h10, 8'h00, "R4 no strobe");

    // R3 seconds-only mode on alarm 1
    tick(7'h45, 7'h01, 7'h02, 7'h05);
    peek(8'h10, 8'h02, "R3 seconds mode");
    pin("R5 pin1", 1'b1, 1'b0);

    // R6 merged routing
    wr(8'h8F, 8'h03);
    peek(8'h10, 8'h02, "R6 flag kept");
    pin("R6 merged", 1'b0, 1'b1);

    // R7 write clears
    wr(8'h8B, 8'h45);
    peek(8'h10, 8'h00, "R7 write clear");

    // R3 seconds+minutes mode
    wr(8'h8C, 8'h22);
    tick(7'h45, 7'h22, 7'h11, 7'h06);
    peek(8'h10, 8'h02, "R3 min+sec match");
    rd(8'h0C, "R7 read alarm1");
    tick(7'h45, 7'h23, 7'h11, 7'h06);
    peek(8'h10, 8'h00, "R3 minute differs");

    // R3 hours+minutes+seconds mode
    wr(8'h8D, 8'h11);
    tick(7'h45, 7'h22, 7'h11, 7'h01);
    peek(8'h10, 8'h02, "R3 hour mode match");
    rd(8'h0D, "R7 read alarm1");
    tick(7'h45, 7'h22, 7'h12, 7'h01);
    peek(8'h10, 8'h00, "R3 hour differs");

    // R3 every-second mode on alarm 0
    wr(8'h87, 8'h80); wr(8'h88, 8'h80); wr(8'h89, 8'h80); wr(8'h8A, 8'h80);
    tick(7'h00, 7'h00, 7'h00, 7'h00);
    peek(8'h10, 8'h01, "R3 all masked");
    rd(8'h0B, "R7 other alarm");
    peek(8'h10, 8'h01, "R7 other alarm keeps flag");
    rd(8'h07, "R7 read alarm0");
    peek(8'h10, 8'h00, "R7 cleared");

    // R8 set beats clear
    @(negedge clk); addr = 8'h07; rdEn = 1'b1; tickStb = 1'b1;
    @(negedge clk); rdEn = 1'b0; tickStb = 1'b0;
    peek(8'h10, 8'h01, "R8 set wins");

    // R11 enables gate pins only
    wr(8'h8F, 8'h04);
    rd(8'h07, "R7 read alarm0");
    tick(7'h01, 7'h01, 7'h01, 7'h01);
    peek(8'h10, 8'h01, "R11 flag without enable");
    pin("R11 pins idle", 1'b1, 1'b1);

    // R9 write protect
    wr(8'h8F, 8'h44);
    peek(8'h0F, 8'h44, "R9 lock set");
    wr(8'h87, 8'h12);
    peek(8'h07, 8'h80, "R9 alarm write blocked");
    peek(8'h10, 8'h00, "R7 clear while locked");
    wr(8'h8F, 8'hC7);
    peek(8'h0F, 8'h44, "R9 locked control");
    wr(8'h8F, 8'h03);
    peek(8'h0F, 8'h04, "R9 unlock only");
    wr(8'h8F, 8'h03);
    peek(8'h0F, 8'h03, "R9 unlocked write");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule